// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence of one SDRAM READ or WRITE burst. A memory controller gives it the current mode register image, a start pulse with the starting column, and a write flag. From the clock edge that samples the start, it presents one column per cycle on `col_out`, marks the final beat of a fixed-length burst, and drops `col_valid` when the burst completes or is terminated.

The mode register image is decoded on the fly. The length code, burst type and write-single bit set the beat count and the address order. The CAS latency field appears as a small number. Any reserved or illegal combination raises `mode_bad`, and a start under such a mode is refused. Fixed bursts of 2, 4 or 8 stay inside their naturally aligned block and wrap there, using either a counting order or an XOR order. A full-page burst counts through the entire row, wraps at the row end and keeps going until the controller terminates it. The column width is a parameter (9, 10 or 11 bits).

Top module: `burst_colgen`

## Requirements
- R1: After reset, `col_valid` and `last_beat` are 0 until a start is accepted.
- R2: A start sampled while `mode_bad` is 0 makes `col_valid` 1 in the next cycle, with `col_out` equal to the sampled start column (beat 0). A start that arrives during a burst discards that burst and begins the new one in the same way.
- R3: With type bit mode_word[3]=0 and length code mode_word[2:0] of 001/010/011 (2/4/8 beats), the low 1/2/3 column bits count up modulo the length from the start value, and the upper bits stay those of the start column (for example start 5 at length 8 gives 5,6,7,0,1,2,3,4).
- R4: With mode_word[3]=1, the low bits of beat k are the start's low bits XOR k (for example start 5 at length 8 gives 5,4,7,6,1,0,3,2).
- R5: Length code 111 with mode_word[3]=0 is a full-page burst. The column increments by one per beat, wraps from all ones to 0, and runs until it is terminated. `last_beat` is never 1 during it.
- R6: Length code 000 gives exactly one beat at the start column, whatever the type bit.
- R7: `last_beat` is 1 exactly on the final beat of a fixed-length burst. In the following cycle `col_valid` is 0 unless a new start was sampled.
- R8: When mode_word[9]=1, a start with `is_write`=1 gives a single beat, while a start with `is_write`=0 uses the programmed length.
- R9: A `stop` sampled during a burst ends it: `col_valid` is 0 in the next cycle unless `start` was sampled on the same edge.
- R10: `mode_bad` is 1 when any of these holds: the length code is one of 100/101/110; the length code is 111 with mode_word[3]=1; the CAS field mode_word[6:4] is not 010 or 011; mode_word[8:7] is not 00; mode_word[12:10] is not 000. While `mode_bad` is 1, a start is ignored.
- R11: `cas_lat` is 2 for CAS field 010, 3 for 011, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_word | input | 13 | Mode register image |
| start | input | 1 | Begin a burst at `start_col` |
| is_write | input | 1 | Burst is a WRITE |
| start_col | input | COL_W | Starting column |
| stop | input | 1 | Terminate the running burst |
| col_out | output | COL_W | Column of the current beat |
| col_valid | output | 1 | `col_out` holds a beat |
| last_beat | output | 1 | Final beat of a fixed-length burst |
| mode_bad | output | 1 | Mode image holds a reserved code |
| cas_lat | output | 2 | Decoded CAS latency (2, 3, or 0 if reserved) |

## Verification
The assertions take for granted that `mode_word` and `is_write` stay constant from a start until that burst ends or is restarted, because the generator reads them only when a start is sampled. The bench changes them only in the cycle of a new start, or while the generator is idle. It drives every input on the falling edge, so each rising edge sees stable values. Terminates and restarts are placed on chosen beats so that the expected sequence can be cut off at a known point.

// File: rtl/colgen_pkg.sv
// Shared constants and types for the burst column generator.
// Assumes a 13-bit mode register image with fields at fixed bit positions.
package colgen_pkg;
    localparam int MODE_W = 13;

    // burst length codes (mode bits 2:0)
    localparam logic [2:0] LEN_ONE  = 3'b000;
    localparam logic [2:0] LEN_TWO  = 3'b001;
    localparam logic [2:0] LEN_FOUR = 3'b010;
    localparam logic [2:0] LEN_EGT  = 3'b011;
    localparam logic [2:0] LEN_PAGE = 3'b111;

    // CAS latency codes (mode bits 6:4)
    localparam logic [2:0] CAS_TWO   = 3'b010;
    localparam logic [2:0] CAS_THREE = 3'b011;

    typedef struct packed {
        logic [2:0] len_code;
        logic       xor_order;
        logic       wr_single;
        logic [1:0] cas;
        logic       bad;
    } mode_fields_t;
endpackage

// File: rtl/colgen_mode_decode.sv
// Decodes the mode register image into burst controls and flags
// every reserved combination. Purely combinational.
// Assumes the field positions given in colgen_pkg.
module colgen_mode_decode
    import colgen_pkg::*;
(
    input  logic [MODE_W-1:0] mode_word,
    output mode_fields_t      fields
);
    logic [2:0] len_f;
    logic [2:0] cas_f;
    logic [1:0] op_f;
    logic [2:0] hi_f;
    logic       len_bad;
    logic       cas_bad;

    assign len_f = mode_word[2:0];
    assign cas_f = mode_word[6:4];
    assign op_f  = mode_word[8:7];
    assign hi_f  = mode_word[12:10];

    // legal burst length codes; full page only in counting order
    always_comb begin
        unique case (len_f)
            LEN_ONE, LEN_TWO, LEN_FOUR, LEN_EGT: len_bad = 1'b0;
            LEN_PAGE:                            len_bad = mode_word[3];
            default:                             len_bad = 1'b1;
        endcase
    end

    // CAS latency number and its legality
    always_comb begin
        unique case (cas_f)
            CAS_TWO:   begin fields.cas = 2'd2; cas_bad = 1'b0; end
            CAS_THREE: begin fields.cas = 2'd3; cas_bad = 1'b0; end
            default:   begin fields.cas = 2'd0; cas_bad = 1'b1; end
        endcase
    end

    // remaining fields and the combined reserved flag
    always_comb begin
        fields.len_code  = len_f;
        fields.xor_order = mode_word[3];
        fields.wr_single = mode_word[9];
        fields.bad       = len_bad | cas_bad | (op_f != 2'b00) | (hi_f != 3'b000);
    end
endmodule

// File: rtl/colgen_burst_cfg.sv
// Captures the per-burst setup at an accepted start: base column,
// wrap mask, order, and full-page flag. The write-single mode folds
// into a one-beat mask here.
// Assumes launch is only raised for a legal mode.
module colgen_burst_cfg
    import colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             is_write,
    input  logic [COL_W-1:0] start_col,
    input  mode_fields_t     fields,
    output logic [COL_W-1:0] base_q,
    output logic [COL_W-1:0] mask_q,
    output logic             xor_q,
    output logic             page_q
);
    logic [COL_W-1:0] mask_d;
    logic             page_d;
    logic             single;

    assign single = is_write & fields.wr_single;

    // wrap mask for the effective length of the new burst
    always_comb begin
        page_d = 1'b0;
        if (single) begin
            mask_d = '0;
        end else begin
            unique case (fields.len_code)
                LEN_TWO:  mask_d = COL_W'(1);
                LEN_FOUR: mask_d = COL_W'(3);
                LEN_EGT:  mask_d = COL_W'(7);
                LEN_PAGE: begin mask_d = '1; page_d = 1'b1; end
                default:  mask_d = '0;
            endcase
        end
    end

    // hold the setup for the whole burst
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            xor_q  <= 1'b0;
            page_q <= 1'b0;
        end else if (launch) begin
            base_q <= start_col;
            mask_q <= mask_d;
            xor_q  <= fields.xor_order;
            page_q <= page_d;
        end
    end
endmodule

// File: rtl/colgen_beat_ctr.sv
// Tracks whether a burst runs and which beat it is on; detects the
// final beat of fixed bursts. A launch always wins over stop and end.
// Assumes mask_q and page_q are updated on the same edge as launch.
module colgen_beat_ctr #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             stop,
    input  logic [COL_W-1:0] mask_q,
    input  logic             page_q,
    output logic             active_q,
    output logic [COL_W-1:0] beat_q,
    output logic             last
);
    // final beat: count reached length-1 and the burst is not full page
    assign last = active_q & ~page_q & (beat_q == mask_q);

    // run state and beat count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            beat_q   <= '0;
        end else if (launch) begin
            active_q <= 1'b1;
            beat_q   <= '0;
        end else if (active_q && (stop || last)) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            beat_q   <= beat_q + COL_W'(1);
        end
    end
endmodule

// File: rtl/colgen_col_mix.sv
// Forms the column of the current beat: bits outside the mask come
// from the base, bits inside are a wrapped sum or an XOR with the beat.
// Purely combinational; full page uses an all-ones mask.
module colgen_col_mix #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_q,
    input  logic [COL_W-1:0] mask_q,
    input  logic             xor_q,
    input  logic [COL_W-1:0] beat_q,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] sum_v;
    logic [COL_W-1:0] xor_v;

    assign sum_v = base_q + beat_q;
    assign xor_v = base_q ^ beat_q;

    // per-bit select between kept base bits and the ordered low bits
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign col[i] = mask_q[i] ? (xor_q ? xor_v[i] : sum_v[i]) : base_q[i];
    end
endmodule

// File: rtl/burst_colgen.sv
// Top of the burst column generator. Decodes the mode image, accepts
// a start only for a legal mode, and streams one column per cycle.
// Assumes mode_word and is_write are steady while a burst runs.
module burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [12:0]       mode_word,
    input  logic              start,
    input  logic              is_write,
    input  logic [COL_W-1:0]  start_col,
    input  logic              stop,
    output logic [COL_W-1:0]  col_out,
    output logic              col_valid,
    output logic              last_beat,
    output logic              mode_bad,
    output logic [1:0]        cas_lat
);
    mode_fields_t     fields;
    logic             launch;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic             xor_q;
    logic             page_q;
    logic             active_q;
    logic [COL_W-1:0] beat_q;
    logic             last;

    colgen_mode_decode u_dec (
        .mode_word (mode_word),
        .fields    (fields)
    );

    assign launch = start & ~fields.bad;

    colgen_burst_cfg #(.COL_W(COL_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .is_write  (is_write),
        .start_col (start_col),
        .fields    (fields),
        .base_q    (base_q),
        .mask_q    (mask_q),
        .xor_q     (xor_q),
        .page_q    (page_q)
    );

    colgen_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .stop     (stop),
        .mask_q   (mask_q),
        .page_q   (page_q),
        .active_q (active_q),
        .beat_q   (beat_q),
        .last     (last)
    );

    colgen_col_mix #(.COL_W(COL_W)) u_mix (
        .base_q (base_q),
        .mask_q (mask_q),
        .xor_q  (xor_q),
        .beat_q (beat_q),
        .col    (col_out)
    );

    assign col_valid = active_q;
    assign last_beat = last;
    assign mode_bad  = fields.bad;
    assign cas_lat   = fields.cas;
endmodule

// File: rtl/burst_colgen_chk.sv
// Protocol checker for burst_colgen, attached by bind.
// Assumes mode_word is steady during a burst.
module burst_colgen_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             stop,
    input logic [COL_W-1:0] col_out,
    input logic             col_valid,
    input logic             last_beat,
    input logic             mode_bad
);
    p_start_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start && !mode_bad |=> col_valid && col_out == $past(start_col));

    p_runs_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && !start && !stop && !last_beat |=> col_valid);

    p_last_in_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> col_valid);

    p_end_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat && !start |=> !col_valid);

    p_stop_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && stop && !start |=> !col_valid);

    p_bad_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid && start && mode_bad |=> !col_valid);
endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_col (start_col),
    .stop      (stop),
    .col_out   (col_out),
    .col_valid (col_valid),
    .last_beat (last_beat),
    .mode_bad  (mode_bad)
);

// File: tb/burst_colgen_tb_top.sv
// Scoreboard bench: the driver queues expected beats, the monitor
// pops and compares them whenever the generator shows a beat.
`timescale 1ns/1ps
module burst_colgen_tb_top;
    localparam int COL_W = 10;

    typedef struct {
        logic [COL_W-1:0] col;
        logic             last;
        string            tag;
    } beat_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [12:0]      mode_word = '0;
    logic             start = 1'b0;
    logic             is_write = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic             stop = 1'b0;
    logic [COL_W-1:0] col_out;
    logic             col_valid;
    logic             last_beat;
    logic             mode_bad;
    logic [1:0]       cas_lat;

    int    n_tests = 0;
    int    n_fail  = 0;
    beat_t exp_q[$];

    always #10 clk = ~clk;

    burst_colgen #(.COL_W(COL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .start(start),
        .is_write(is_write), .start_col(start_col), .stop(stop),
        .col_out(col_out), .col_valid(col_valid), .last_beat(last_beat),
        .mode_bad(mode_bad), .cas_lat(cas_lat)
    );

    // mode image: [12:10] spare, [9] write single, [8:7] op, [6:4] CAS, [3] type, [2:0] length
    function automatic logic [12:0] mk(input logic [2:0] len, input bit bt,
                                       input logic [2:0] cas, input logic [1:0] op,
                                       input bit wb, input logic [2:0] hi);
        return {hi, wb, op, cas, bt, len};
    endfunction

    // expected column of beat k; n = beats (0 for full page)
    function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] b, input bit ilv,
                                                 input int n, input int k);
        int bi;
        int lo;
        int blk;
        bi = int'(b);
        if (n == 0) return COL_W'(bi + k);
        blk = bi - (bi % n);
        lo  = ilv ? ((bi % n) ^ k) : (((bi % n) + k) % n);
        return COL_W'(blk + lo);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // queue beats and run one burst; called and returns at a falling edge
    task automatic launch(input logic [12:0] m, input bit wr, input logic [COL_W-1:0] c,
                          input int n, input bit ilv, input int nshow, input bit do_stop,
                          input string tag);
        for (int k = 0; k < nshow; k++) begin
            beat_t it;
            it.col  = exp_col(c, ilv, n, k);
            it.last = (n != 0) && (k == n - 1);
            it.tag  = tag;
            exp_q.push_back(it);
        end
        mode_word = m; is_write = wr; start_col = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (nshow - 1) @(negedge clk);
        if (do_stop) begin
            stop = 1'b1;
            @(negedge clk);
            stop = 1'b0;
        end
    endtask

    task automatic expect_idle(input string tag);
        @(negedge clk);
        check(col_valid == 1'b0, tag, "valid after burst", int'(col_valid), 0);
        check(exp_q.size() == 0, tag, "beats left in queue", exp_q.size(), 0);
    endtask

    // monitor: compare each shown beat with the head of the queue
    always @(posedge clk) begin
        #5;
        if (rst_n && col_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected beat col", int'(col_out), -1);
            end else begin
                beat_t it;
                it = exp_q.pop_front();
                check(col_out == it.col, it.tag, "column", int'(col_out), int'(it.col));
                check(last_beat == it.last, it.tag, "last flag", int'(last_beat), int'(it.last));
            end
        end
    end

    // watchdog
    initial begin
        #(20 * 100000);
        check(1'b0, "R1", "watchdog expired", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [12:0] seq8, ilv8, seq4, ilv2, one_i, page, wbm;
        seq8  = mk(3'b011, 0, 3'b010, 2'b00, 0, 3'b000);
        ilv8  = mk(3'b011, 1, 3'b011, 2'b00, 0, 3'b000);
        seq4  = mk(3'b010, 0, 3'b010, 2'b00, 0, 3'b000);
        ilv2  = mk(3'b001, 1, 3'b010, 2'b00, 0, 3'b000);
        one_i = mk(3'b000, 1, 3'b010, 2'b00, 0, 3'b000);
        page  = mk(3'b111, 0, 3'b011, 2'b00, 0, 3'b000);
        wbm   = mk(3'b011, 0, 3'b010, 2'b00, 1, 3'b000);

        repeat (3) @(negedge clk);
        check(col_valid == 1'b0 && last_beat == 1'b0, "R1", "reset outputs",
              int'({col_valid, last_beat}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(col_valid == 1'b0, "R1", "idle after reset", int'(col_valid), 0);

        // R3: counting order, start 5 in block 0xC0
        launch(seq8, 0, 10'h0C5, 8, 0, 8, 0, "R3");
        expect_idle("R7");
        // R4: XOR order, same start
        launch(ilv8, 0, 10'h0C5, 8, 1, 8, 0, "R4");
        expect_idle("R7");
        // R3: length 4 wraps inside top block
        launch(seq4, 0, 10'h3FE, 4, 0, 4, 0, "R3");
        expect_idle("R7");
        // R4: length 2 XOR order
        launch(ilv2, 0, 10'h101, 2, 1, 2, 0, "R4");
        expect_idle("R7");
        // R6: single beat, type bit set but ignored
        launch(one_i, 0, 10'h2A7, 1, 1, 1, 0, "R6");
        expect_idle("R6");
        // R5 with R9: full page wraps at row end, stopped after 6 beats
        launch(page, 0, 10'h3FD, 0, 0, 6, 1, "R5");
        check(col_valid == 1'b0, "R9", "valid after stop", int'(col_valid), 0);
        expect_idle("R5");
        // R8: write single mode
        launch(wbm, 1, 10'h047, 1, 0, 1, 0, "R8");
        expect_idle("R8");
        launch(wbm, 0, 10'h047, 8, 0, 8, 0, "R8");
        expect_idle("R8");
        // R9: stop on third beat of fixed burst
        launch(seq8, 0, 10'h010, 8, 0, 3, 1, "R9");
        check(col_valid == 1'b0, "R9", "valid after stop", int'(col_valid), 0);
        expect_idle("R9");
        // R2: restart in mid burst
        launch(seq8, 0, 10'h0A3, 8, 0, 3, 0, "R2");
        launch(seq4, 0, 10'h011, 4, 0, 4, 0, "R2");
        expect_idle("R2");

        // R10: reserved codes
        mode_word = mk(3'b100, 0, 3'b010, 2'b00, 0, 3'b000); #1;
        check(mode_bad == 1'b1, "R10", "length 100", int'(mode_bad), 1);
        mode_word = mk(3'b111, 1, 3'b010, 2'b00, 0, 3'b000); #1;
        check(mode_bad == 1'b1, "R10", "page with XOR", int'(mode_bad), 1);
        mode_word = mk(3'b011, 0, 3'b001, 2'b00, 0, 3'b000); #1;
        check(mode_bad == 1'b1, "R10", "CAS 001", int'(mode_bad), 1);
        mode_word = mk(3'b011, 0, 3'b010, 2'b01, 0, 3'b000); #1;
        check(mode_bad == 1'b1, "R10", "op 01", int'(mode_bad), 1);
        mode_word = mk(3'b011, 0, 3'b010, 2'b00, 0, 3'b001); #1;
        check(mode_bad == 1'b1, "R10", "spare bit", int'(mode_bad), 1);
        mode_word = seq8; #1;
        check(mode_bad == 1'b0, "R10", "legal mode", int'(mode_bad), 0);
        // R10: start refused under reserved mode
        @(negedge clk);
        mode_word = mk(3'b101, 0, 3'b010, 2'b00, 0, 3'b000);
        start_col = 10'h155; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(col_valid == 1'b0, "R10", "refused start", int'(col_valid), 0);
        repeat (2) @(negedge clk);
        check(col_valid == 1'b0, "R10", "still idle", int'(col_valid), 0);

        // R11: CAS latency decode
        mode_word = mk(3'b011, 0, 3'b010, 2'b00, 0, 3'b000); #1;
        check(cas_lat == 2'd2, "R11", "CAS 010", int'(cas_lat), 2);
        mode_word = mk(3'b011, 0, 3'b011, 2'b00, 0, 3'b000); #1;
        check(cas_lat == 2'd3, "R11", "CAS 011", int'(cas_lat), 3);
        mode_word = mk(3'b011, 0, 3'b110, 2'b00, 0, 3'b000); #1;
        check(cas_lat == 2'd0, "R11", "CAS 110", int'(cas_lat), 0);

        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule